// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Control

This block holds the per-port control and status bits of a USB 2.0 host controller that deal with port enable, selective suspend, resume signalling and over-current reporting. Software reaches it through a one-cycle write strobe carrying a byte of register data plus a separate byte of clear bits for the write-one-to-clear fields. The current register value is always visible on a combinational read bus.

The hardware side feeds in whether a bus transaction is still running, a pulse when the line decoder sees a J-to-K transition, an indication that the port has reached high-speed idle, the over-current sense line and a 1 ms tick. The block answers with a one-cycle port-change pulse for the global status logic, a level that tells the port logic to drive resume K, and a level that stops downstream traffic while the port sleeps. A suspend request made mid-transaction is held back until the transaction ends. Ending a resume waits for high-speed idle, bounded by a tick-counted timeout.

Top module: `usb_port_pm`

## Requirements
- R1: After a synchronous active-low reset every register bit reads 0 and port_change, drive_resume_k and block_downstream are all 0.
- R2: Read layout: bit0 enable, bit1 suspend, bit2 force-resume, bit3 port-reset, bit4 over-current active, bit5 over-current change, bit6 resume timeout, bit7 always 0. A write loads bit0 and bit3 directly from wr_data; the port is disabled when bit0 is 0, enabled for {bit0,bit1}=10, suspended for 11.
- R3: Writing wr_data[1]=1 while the port is enabled, not suspended, and txn_active is 0 sets the suspend bit at that clock edge; block_downstream equals the suspend bit.
- R4: If txn_active is 1 when such a request is written, the suspend bit stays 0 and traffic stays unblocked until the first clock edge at which txn_active is 0, where the suspend bit becomes 1. A write with wr_data[0]=0 cancels a held request.
- R5: Writing 0 to bit1 never clears the suspend bit, and writing 1 to bit1 while the enable bit is 0 has no effect.
- R6: A write that takes bit3 from 0 to 1 clears suspend, force-resume and any held suspend request, and wins over a suspend request or a J-to-K detect in the same cycle.
- R7: A j_to_k pulse while suspended and force-resume is 0 sets force-resume and gives exactly one cycle of port_change at the same edge. A software write of 1 to bit2 sets force-resume without port_change; j_to_k while not suspended does nothing.
- R8: drive_resume_k is 1 while force-resume is 1 and no resume end is in progress. A write with bit2=0 while force-resume is 1 starts the resume end: drive_resume_k drops at once, force-resume stays 1 until the edge where hs_idle is 1, and then force-resume and suspend both clear.
- R9: If hs_idle is not seen, force-resume and suspend are cleared at the TIMEOUT_TICKS-th ms_tick after the resume-end write (default 2) and bit6 is set; hs_idle in the same cycle wins. A write with clr_bits[6]=1 clears bit6.
- R10: Bit4 follows oc_sense one clock later. Bit5 is set at every change of bit4 and cleared by a write with clr_bits[5]=1; a change in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_data | input | 8 | Register write data |
| clr_bits | input | 8 | Write-one-to-clear mask, used with wr_en |
| txn_active | input | 1 | A bus transaction is in progress on the port |
| j_to_k | input | 1 | J-to-K transition detected on the line |
| hs_idle | input | 1 | Port has reached high-speed idle |
| oc_sense | input | 1 | Over-current condition present |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| rd_data | output | 8 | Current register value |
| port_change | output | 1 | One-cycle pulse on hardware-detected resume |
| drive_resume_k | output | 1 | Drive resume K on the port |
| block_downstream | output | 1 | Block downstream traffic |

## Verification
The hardest situations to reach from the ports are the same-cycle collisions: a held suspend request still waiting on txn_active when port reset rises, a J-to-K pulse landing on the same edge as the reset write, and the timeout tick arriving without hs_idle. Directed sequences build each state step by step, holding txn_active high across several cycles before the reset write and issuing the resume-end write with hs_idle kept low across two ticks. A long seeded random phase then mixes writes, rare hs_idle and J-to-K pulses and over-current toggles, compared cycle by cycle against a bench model.

// File: rtl/usbp_pkg.sv
// Shared bit positions of the port control word.
// Assumes an 8-bit register; unused bits read as 0.
package usbp_pkg;
    localparam int REG_W    = 8;
    localparam int BIT_EN   = 0;
    localparam int BIT_SUS  = 1;
    localparam int BIT_FR   = 2;
    localparam int BIT_PRST = 3;
    localparam int BIT_OCA  = 4;
    localparam int BIT_OCC  = 5;
    localparam int BIT_TO   = 6;
endpackage

// File: rtl/usbp_suspend_ctl.sv
// Suspend bit with deferred entry.
// A request made while a transaction runs is held until txn_active drops.
// Assumes reset_rise and resume_done are single-cycle events.
module usbp_suspend_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic en_q,
    input  logic sus_req,
    input  logic dis_wr,
    input  logic txn_active,
    input  logic reset_rise,
    input  logic resume_done,
    output logic susp_q
);
    logic pend_q;
    logic take;

    // a new request counts only when enabled, idle and not preempted by reset
    assign take = sus_req && en_q && !susp_q && !pend_q && !reset_rise;

    // update suspend and the held request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (reset_rise || resume_done) begin
            susp_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (dis_wr) begin
            pend_q <= 1'b0;
        end else if (pend_q && !txn_active) begin
            susp_q <= 1'b1;
            pend_q <= 1'b0;
        end else if (take) begin
            if (txn_active) pend_q <= 1'b1;
            else            susp_q <= 1'b1;
        end
    end

    // R4: suspend never starts during a transaction
    assert_susp_deferred_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(susp_q) |-> !$past(txn_active));
    // R6: rising port reset leaves the port unsuspended
    assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reset_rise |=> !susp_q && !pend_q);
endmodule

// File: rtl/usbp_resume_ctl.sv
// Force-resume bit, resume-end handshake and timeout.
// Assumes ms_tick is a one-cycle pulse; the timeout fires on the
// TIMEOUT_TICKS-th tick after the resume-end write.
module usbp_resume_ctl #(
    parameter int TIMEOUT_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic fr_wr_bit,
    input  logic susp_q,
    input  logic j_to_k,
    input  logic hs_idle,
    input  logic ms_tick,
    input  logic reset_rise,
    input  logic to_clr,
    output logic fr_q,
    output logic ending_q,
    output logic to_q,
    output logic change_q,
    output logic resume_done
);
    localparam int CNT_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic hw_wake, sw_set, start_end, tick_out;

    assign hw_wake   = j_to_k && susp_q && !fr_q && !reset_rise;
    assign sw_set    = wr_en && fr_wr_bit && !fr_q && !reset_rise;
    assign start_end = wr_en && !fr_wr_bit && fr_q && !ending_q && !reset_rise;
    assign tick_out  = ending_q && ms_tick && !hs_idle && (cnt_q == LAST);
    assign resume_done = ending_q && (hs_idle || tick_out) && !reset_rise;

    // force-resume and resume-end sequencing
    always_ff @(posedge clk) begin
        if (!rst_n || reset_rise || resume_done) begin
            fr_q     <= 1'b0;
            ending_q <= 1'b0;
            cnt_q    <= '0;
        end else if (hw_wake || sw_set) begin
            fr_q <= 1'b1;
        end else if (start_end) begin
            ending_q <= 1'b1;
            cnt_q    <= '0;
        end else if (ending_q && ms_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // one-cycle change pulse for hardware-detected resume only
    always_ff @(posedge clk) begin
        if (!rst_n) change_q <= 1'b0;
        else        change_q <= hw_wake;
    end

    // sticky timeout flag, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        to_q <= 1'b0;
        else if (tick_out) to_q <= 1'b1;
        else if (to_clr)   to_q <= 1'b0;
    end

    // R7: change pulse lasts one cycle and comes with force-resume
    assert_change_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        change_q |-> fr_q ##1 !change_q);
    // R8: resume end only runs while force-resume is held
    assert_ending_holds_fr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ending_q |-> fr_q);
    // R9: timeout only follows a pending resume end
    assert_timeout_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_q) |-> $past(ending_q) && !fr_q);
endmodule

// File: rtl/usbp_overcurrent.sv
// Over-current active mirror and sticky change flag.
// Assumes oc_sense is already synchronous to clk.
module usbp_overcurrent (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_sense,
    input  logic occ_clr,
    output logic oca_q,
    output logic occ_q
);
    // mirror sense and record changes, change wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oca_q <= 1'b0;
            occ_q <= 1'b0;
        end else begin
            oca_q <= oc_sense;
            if (oc_sense != oca_q) occ_q <= 1'b1;
            else if (occ_clr)      occ_q <= 1'b0;
        end
    end

    // R10: every change of the active bit leaves the change flag set
    assert_occ_on_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_sense != oca_q) |=> occ_q);
endmodule

// File: rtl/usb_port_pm.sv
// Port suspend/resume/over-current control word of a USB 2.0 host port.
// Holds enable and port-reset directly, delegates suspend, resume and
// over-current to submodules, and presents the word combinationally.
// Assumes synchronous inputs and a one-cycle write strobe.
module usb_port_pm
    import usbp_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic [REG_W-1:0] clr_bits,
    input  logic             txn_active,
    input  logic             j_to_k,
    input  logic             hs_idle,
    input  logic             oc_sense,
    input  logic             ms_tick,
    output logic [REG_W-1:0] rd_data,
    output logic             port_change,
    output logic             drive_resume_k,
    output logic             block_downstream
);
    logic en_q, prst_q, reset_rise;
    logic susp_q, fr_q, ending_q, to_q, change_q, resume_done;
    logic oca_q, occ_q;

    assign reset_rise = wr_en && wr_data[BIT_PRST] && !prst_q;

    // software-owned enable and port-reset bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            prst_q <= 1'b0;
        end else if (wr_en) begin
            en_q   <= wr_data[BIT_EN];
            prst_q <= wr_data[BIT_PRST];
        end
    end

    usbp_suspend_ctl u_susp (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_q        (en_q),
        .sus_req     (wr_en && wr_data[BIT_SUS]),
        .dis_wr      (wr_en && !wr_data[BIT_EN]),
        .txn_active  (txn_active),
        .reset_rise  (reset_rise),
        .resume_done (resume_done),
        .susp_q      (susp_q)
    );

    usbp_resume_ctl #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_res (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .fr_wr_bit   (wr_data[BIT_FR]),
        .susp_q      (susp_q),
        .j_to_k      (j_to_k),
        .hs_idle     (hs_idle),
        .ms_tick     (ms_tick),
        .reset_rise  (reset_rise),
        .to_clr      (wr_en && clr_bits[BIT_TO]),
        .fr_q        (fr_q),
        .ending_q    (ending_q),
        .to_q        (to_q),
        .change_q    (change_q),
        .resume_done (resume_done)
    );

    usbp_overcurrent u_oc (
        .clk     (clk),
        .rst_n   (rst_n),
        .oc_sense(oc_sense),
        .occ_clr (wr_en && clr_bits[BIT_OCC]),
        .oca_q   (oca_q),
        .occ_q   (occ_q)
    );

    // assemble the readable word
    always_comb begin
        rd_data           = '0;
        rd_data[BIT_EN]   = en_q;
        rd_data[BIT_SUS]  = susp_q;
        rd_data[BIT_FR]   = fr_q;
        rd_data[BIT_PRST] = prst_q;
        rd_data[BIT_OCA]  = oca_q;
        rd_data[BIT_OCC]  = occ_q;
        rd_data[BIT_TO]   = to_q;
    end

    assign port_change      = change_q;
    assign drive_resume_k   = fr_q && !ending_q;
    assign block_downstream = susp_q;

    // R5: suspend never appears on a port that was disabled
    assert_no_susp_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !susp_q) |=> !susp_q);
endmodule

// File: tb/usb_port_pm_test.sv
module usb_port_pm_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0, clr_bits = '0;
    logic txn_active = 1'b0, j_to_k = 1'b0, hs_idle = 1'b0, oc_sense = 1'b0, ms_tick = 1'b0;
    logic [7:0] rd_data;
    logic port_change, drive_resume_k, block_downstream;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    usb_port_pm uut (.*);

    // bench model built from the requirements
    logic m_en = 0, m_sus = 0, m_pend = 0, m_fr = 0, m_end = 0, m_to = 0;
    logic m_oca = 0, m_occ = 0, m_prst = 0, m_chg = 0;
    int m_cnt = 0;
    always @(posedge clk) begin
        bit rr, hw, sws, se, tko, drop, take;
        if (!rst_n) begin
            m_en <= 0; m_sus <= 0; m_pend <= 0; m_fr <= 0; m_end <= 0; m_to <= 0;
            m_oca <= 0; m_occ <= 0; m_prst <= 0; m_chg <= 0; m_cnt <= 0;
        end else begin
            rr   = wr_en && wr_data[3] && !m_prst;
            hw   = j_to_k && m_sus && !m_fr && !rr;
            sws  = wr_en && wr_data[2] && !m_fr && !rr;
            se   = wr_en && !wr_data[2] && m_fr && !m_end && !rr;
            tko  = m_end && ms_tick && !hs_idle && (m_cnt == 1);
            drop = m_end && (hs_idle || tko) && !rr;
            take = wr_en && wr_data[1] && m_en && !m_sus && !m_pend && !rr;
            if (wr_en) begin m_en <= wr_data[0]; m_prst <= wr_data[3]; end
            if (rr || drop) begin m_sus <= 0; m_pend <= 0; end
            else if (wr_en && !wr_data[0]) m_pend <= 0;
            else if (m_pend && !txn_active) begin m_sus <= 1; m_pend <= 0; end
            else if (take) begin
                if (txn_active) m_pend <= 1; else m_sus <= 1;
            end
            if (rr || drop) begin m_fr <= 0; m_end <= 0; m_cnt <= 0; end
            else if (hw || sws) m_fr <= 1;
            else if (se) begin m_end <= 1; m_cnt <= 0; end
            else if (m_end && ms_tick) m_cnt <= m_cnt + 1;
            m_chg <= hw;
            if (tko) m_to <= 1; else if (wr_en && clr_bits[6]) m_to <= 0;
            m_oca <= oc_sense;
            if (oc_sense != m_oca) m_occ <= 1; else if (wr_en && clr_bits[5]) m_occ <= 0;
        end
    end

    function automatic logic [7:0] model_word();
        return {1'b0, m_to, m_occ, m_oca, m_prst, m_fr, m_sus, m_en};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one-cycle write; returns after the capturing edge, at the falling edge
    task automatic wr(logic [7:0] d, logic [7:0] c);
        wr_en = 1'b1; wr_data = d; clr_bits = c;
        @(negedge clk);
        wr_en = 1'b0; clr_bits = '0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check("R1 reset word", rd_data, 8'h00);
        check("R1 reset outputs", {5'd0, port_change, drive_resume_k, block_downstream}, 8'h00);

        wr(8'h01, 8'h00);
        check("R2 enable write", rd_data, 8'h01);

        txn_active = 1'b1;
        wr(8'h03, 8'h00);
        check("R4 deferred suspend", rd_data, 8'h01);
        step();
        check("R4 still held", {rd_data[1], block_downstream}, 2'b00);
        txn_active = 1'b0;
        step();
        check("R4 suspend after txn", rd_data, 8'h03);
        check("R3 traffic blocked", {7'd0, block_downstream}, 8'h01);

        wr(8'h01, 8'h00);
        check("R5 write zero ignored", rd_data, 8'h03);

        j_to_k = 1'b1; step(); j_to_k = 1'b0;
        check("R7 wake sets force-resume", rd_data, 8'h07);
        check("R7 change pulse", {6'd0, port_change, drive_resume_k}, 8'h03);
        step();
        check("R7 pulse single", {7'd0, port_change}, 8'h00);

        wr(8'h03, 8'h00);
        check("R8 resume end pending", rd_data, 8'h07);
        check("R8 K stops", {7'd0, drive_resume_k}, 8'h00);
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        check("R8 held until idle", rd_data, 8'h07);
        hs_idle = 1'b1; step(); hs_idle = 1'b0;
        check("R8 idle clears resume and suspend", rd_data, 8'h01);

        wr(8'h03, 8'h00);
        wr(8'h07, 8'h00);
        check("R7 software resume no pulse", {rd_data, 7'd0, port_change}, {8'h07, 8'h00});
        wr(8'h03, 8'h00);
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        check("R9 first tick", rd_data, 8'h07);
        step();
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
        check("R9 timeout", rd_data, 8'h41);
        wr(8'h01, 8'h40);
        check("R9 timeout cleared", rd_data, 8'h01);

        wr(8'h00, 8'h00);
        wr(8'h02, 8'h00);
        check("R5 suspend while disabled", rd_data, 8'h00);

        wr(8'h01, 8'h00);
        txn_active = 1'b1;
        wr(8'h03, 8'h00);
        wr(8'h0B, 8'h00);
        txn_active = 1'b0;
        step(); step();
        check("R6 reset cancels held suspend", rd_data, 8'h09);

        wr(8'h01, 8'h00);
        wr(8'h03, 8'h00);
        j_to_k = 1'b1;
        wr(8'h0B, 8'h00);
        j_to_k = 1'b0;
        check("R6 reset beats wake", {rd_data, 7'd0, port_change}, {8'h09, 8'h00});

        wr(8'h01, 8'h00);
        oc_sense = 1'b1; step();
        check("R10 over-current set", rd_data, 8'h31);
        wr(8'h01, 8'h20);
        check("R10 change cleared", rd_data, 8'h11);
        oc_sense = 1'b0; step();
        check("R10 over-current gone", rd_data, 8'h21);
        oc_sense = 1'b1;
        wr(8'h01, 8'h20);
        check("R10 change beats clear", rd_data, 8'h31);

        // seeded random phase against the model
        for (int i = 0; i < 4000; i++) begin
            check("R2-model word", rd_data, model_word());
            check("R7 R8 R3 model outputs", {5'd0, port_change, drive_resume_k, block_downstream},
                  {5'd0, m_chg, m_fr && !m_end, m_sus});
            wr_en      = ($urandom % 5) == 0;
            wr_data    = 8'($urandom);
            wr_data[0] = ($urandom % 10) != 0;
            wr_data[3] = ($urandom % 10) == 0;
            clr_bits   = 8'($urandom);
            txn_active = ($urandom % 3) == 0;
            j_to_k     = ($urandom % 6) == 0;
            hs_idle    = ($urandom % 15) == 0;
            ms_tick    = ($urandom % 5) == 0;
            if (($urandom % 25) == 0) oc_sense = ~oc_sense;
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule